// File: doc/BRIEF.md
# Programmable 16-bit Down Counter/Timer

This block is a down counter with a byte-wide host port. The host writes a 16-bit reload value one byte at a time. It picks a behaviour through a mode byte and drives the counter through a command/status byte. The counter moves only on a one-clock `cnt_en` strobe, so an outside prescaler sets the count rate. A cycle starts either on a host trigger command or, when enabled, on a rising edge of `ext_trig`. The count runs while the gate allows it. At terminal count the block raises a pending flag, and in continuous mode it reloads itself.

The mode byte selects one of three output shapes: a one-clock pulse at terminal count, a level that stays high for the whole cycle, or a square wave. It also holds the continuous, retrigger, external trigger, external gate and output enable controls. With these controls, host software can build the usual interval-timer behaviours: single interrupt on terminal count, retriggerable one-shot, rate generator, square wave and strobes. The host reads the count through a latch command and then takes the high byte before the low byte. When `ctr_on` is low, the command/status byte is held at zero.

Top module: `ctmr_top`

## Requirements
- R1: Reload register: a write to address 2 sets the low byte and a write to address 3 sets the high byte. Both addresses read back what was written.
- R2: A busy counter decrements only on a `cnt_en` strobe while the gate is open. The gate is open when gate bit (command bit 2) is 1 and, if mode bit 4 (external gate enable) is set, `ext_gate` is also high. Every command write loads the gate bit from wdata bit 2.
- R3: Writing command bit 1 loads the reload value and sets busy. A rising edge on `ext_trig` does the same, but only when mode bit 3 is set. During an active cycle a trigger is ignored unless mode bit 5 (retrigger) is set, in which case it reloads the counter.
- R4: The strobe that meets a count of 1 (or 0) is terminal count. In single-cycle mode busy then clears and the count becomes 0. When mode bit 2 (continuous) is set, the count reloads and busy stays set.
- R5: Terminal count sets the pending flag. The flag appears on `irq_pend` and as status bit 5. A command write with bit 4 set clears it, and terminal count wins if both happen in the same cycle.
- R6: `ctr_out` is registered and is forced low unless mode bit 6 (output enable) is set. The shape comes from mode bits 1:0. Code 0 (and the unused code 3) gives a pulse high on the clock after terminal count. Code 1 stays high while busy and drops at terminal count. Code 2 is high while busy with the next count above half the reload value.
- R7: Writing command bit 3 freezes the live count in a holding register, and status bit 3 reads 1. Address 4 returns the high byte and address 5 the low byte. Reading address 5 releases the freeze, and later reads follow the live count.
- R8: While `ctr_on` is low, busy, gate, pending and freeze are cleared and command writes are ignored. Mode and reload writes still take effect.
- R9: After reset all state reads as zero. `rdata` updates on the clock after `rd_en` and holds its value otherwise. The status byte holds busy in bit 0, gate in bit 2, freeze in bit 3 and pending in bit 5, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_on | input | 1 | Counter enable; low clears the command/status state |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Register address (0 mode, 1 command/status, 2/3 reload low/high, 4/5 count high/low) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| cnt_en | input | 1 | One-clock count strobe |
| ext_trig | input | 1 | External trigger, rising edge |
| ext_gate | input | 1 | External gate level |
| ctr_out | output | 1 | Shaped counter output |
| busy | output | 1 | Count cycle in progress |
| irq_pend | output | 1 | Terminal-count pending flag |

## Verification
The properties assume the host never reads and writes in the same clock. They also assume `ext_trig`, `ext_gate` and `cnt_en` are synchronous to `clk`, so a trigger edge and a strobe are each seen for exactly one sampled cycle. The stimulus changes every input on the falling edge and holds each strobe for a single clock. It never combines `rd_en` with `wr_en`, and it reads the count only through the latch sequence, finishing with the low byte.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    DUTY_PULSE   = 2'd0,
    DUTY_ONESHOT = 2'd1,
    DUTY_SQUARE  = 2'd2,
    DUTY_RSVD    = 2'd3
  } duty_e;

  // mode byte, MSB first
  typedef struct packed {
    logic  rsvd;
    logic  out_en;
    logic  retrig;
    logic  xgate_en;
    logic  xtrig_en;
    logic  cont;
    duty_e duty;
  } mode_t;

  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_CMD  = 3'd1;
  localparam logic [2:0] ADR_RLO  = 3'd2;
  localparam logic [2:0] ADR_RHI  = 3'd3;
  localparam logic [2:0] ADR_CHI  = 3'd4;
  localparam logic [2:0] ADR_CLO  = 3'd5;

  localparam int CB_BUSY  = 0;
  localparam int CB_TRIG  = 1;
  localparam int CB_GATE  = 2;
  localparam int CB_LATCH = 3;
  localparam int CB_CLRP  = 4;
  localparam int CB_PEND  = 5;

endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctr_on,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          ext_trig,
  input  logic          ext_gate,
  input  logic          tc,
  output mode_t         mode_q,
  output logic [CW-1:0] reload_q,
  output logic          gate_q,
  output logic          pend_q,
  output logic          trig_any,
  output logic          gate_eff
);

  logic cmd_wr;
  logic xtrig_q;

  assign cmd_wr = wr_en && (addr == ADR_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      reload_q <= '0;
      gate_q   <= 1'b0;
      pend_q   <= 1'b0;
      xtrig_q  <= 1'b0;
    end else begin
      if (wr_en && addr == ADR_MODE) mode_q <= mode_t'(wdata[7:0]);
      if (wr_en && addr == ADR_RLO)  reload_q[DW-1:0]  <= wdata;
      if (wr_en && addr == ADR_RHI)  reload_q[CW-1:DW] <= wdata;
      if (!ctr_on) begin
        gate_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (cmd_wr) gate_q <= wdata[CB_GATE];
        if (tc) pend_q <= 1'b1;
        else if (cmd_wr && wdata[CB_CLRP]) pend_q <= 1'b0;
      end
      xtrig_q <= ext_trig;
    end
  end

  assign trig_any = ctr_on && ((cmd_wr && wdata[CB_TRIG]) ||
                               (mode_q.xtrig_en && ext_trig && !xtrig_q));
  assign gate_eff = gate_q && (!mode_q.xgate_en || ext_gate);

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctr_on,
  input  duty_e         duty,
  input  logic          cont,
  input  logic          retrig,
  input  logic          out_en,
  input  logic [CW-1:0] reload,
  input  logic          trig,
  input  logic          gate,
  input  logic          cnt_en,
  output logic [CW-1:0] cnt_q,
  output logic          busy_q,
  output logic          out_q,
  output logic          tc
);

  logic          load, step, busy_n, shape;
  logic [CW-1:0] cnt_n;

  always_comb begin
    load   = trig && (!busy_q || retrig);
    step   = ctr_on && busy_q && gate && cnt_en && !load;
    tc     = step && (cnt_q <= CW'(1));
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (!ctr_on) begin
      busy_n = 1'b0;
    end else if (load) begin
      cnt_n  = reload;
      busy_n = 1'b1;
    end else if (tc) begin
      if (cont) begin
        cnt_n = reload;
      end else begin
        cnt_n  = '0;
        busy_n = 1'b0;
      end
    end else if (step) begin
      cnt_n = cnt_q - 1'b1;
    end
    case (duty)
      DUTY_ONESHOT: shape = busy_n && !tc;
      DUTY_SQUARE:  shape = busy_n && (cnt_n > (reload >> 1));
      default:      shape = tc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      out_q  <= out_en && shape;
    end
  end

endmodule

// File: rtl/ctmr_rdbk.sv
module ctmr_rdbk
  import ctmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctr_on,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  mode_t         mode,
  input  logic [CW-1:0] reload,
  input  logic          gate,
  input  logic          pend,
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  output logic [DW-1:0] rdata
);

  logic [CW-1:0] hold_q, view;
  logic          frz_q, latch_req;
  logic [DW-1:0] stat, mux;

  assign latch_req = ctr_on && wr_en && (addr == ADR_CMD) && wdata[CB_LATCH];
  assign view      = frz_q ? hold_q : cnt;

  always_comb begin
    stat           = '0;
    stat[CB_BUSY]  = busy;
    stat[CB_GATE]  = gate;
    stat[CB_LATCH] = frz_q;
    stat[CB_PEND]  = pend;
    case (addr)
      ADR_MODE: mux = DW'(mode);
      ADR_CMD:  mux = stat;
      ADR_RLO:  mux = reload[DW-1:0];
      ADR_RHI:  mux = reload[CW-1:DW];
      ADR_CHI:  mux = view[CW-1:DW];
      ADR_CLO:  mux = view[DW-1:0];
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      frz_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (!ctr_on) begin
        frz_q <= 1'b0;
      end else if (latch_req) begin
        hold_q <= cnt;
        frz_q  <= 1'b1;
      end else if (rd_en && addr == ADR_CLO) begin
        frz_q <= 1'b0;
      end
      if (rd_en) rdata <= mux;
    end
  end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctr_on,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cnt_en,
  input  logic          ext_trig,
  input  logic          ext_gate,
  output logic          ctr_out,
  output logic          busy,
  output logic          irq_pend
);

  localparam int CW = 2 * DW;

  mode_t         mode_q;
  logic [CW-1:0] reload_q, cnt_val;
  logic          gate_q, trig_any, gate_eff, tc, out_en;

  assign out_en = mode_q.out_en;

  ctmr_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .ctr_on(ctr_on), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .ext_trig(ext_trig), .ext_gate(ext_gate), .tc(tc),
    .mode_q(mode_q), .reload_q(reload_q), .gate_q(gate_q), .pend_q(irq_pend),
    .trig_any(trig_any), .gate_eff(gate_eff)
  );

  ctmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .ctr_on(ctr_on), .duty(mode_q.duty),
    .cont(mode_q.cont), .retrig(mode_q.retrig), .out_en(out_en),
    .reload(reload_q), .trig(trig_any), .gate(gate_eff), .cnt_en(cnt_en),
    .cnt_q(cnt_val), .busy_q(busy), .out_q(ctr_out), .tc(tc)
  );

  ctmr_rdbk #(.DW(DW), .CW(CW)) u_rdbk (
    .clk(clk), .rst(rst), .ctr_on(ctr_on), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .mode(mode_q), .reload(reload_q),
    .gate(gate_q), .pend(irq_pend), .busy(busy), .cnt(cnt_val), .rdata(rdata)
  );

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ctr_on,
  input logic          cnt_en,
  input logic          busy,
  input logic          irq_pend,
  input logic          ctr_out,
  input logic          trig_any,
  input logic          out_en,
  input logic [CW-1:0] cnt_val
);

  // R8
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !ctr_on |=> (!busy && !irq_pend));

  // R5
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pend) |-> $past(busy));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !trig_any) |=> $stable(cnt_val));

  // R6
  out_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ctr_out |-> $past(out_en));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(trig_any));

endmodule

bind ctmr_top ctmr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctr_on(ctr_on), .cnt_en(cnt_en), .busy(busy),
  .irq_pend(irq_pend), .ctr_out(ctr_out), .trig_any(trig_any),
  .out_en(out_en), .cnt_val(cnt_val)
);

// File: tb/sim_ctmr_top.sv
`timescale 1ns/1ps
module sim_ctmr_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctr_on = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cnt_en = 1'b0, ext_trig = 1'b0, ext_gate = 1'b0;
  logic       ctr_out, busy, irq_pend;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctmr_top u0 (
    .clk(clk), .rst(rst), .ctr_on(ctr_on), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en),
    .ext_trig(ext_trig), .ext_gate(ext_gate), .ctr_out(ctr_out),
    .busy(busy), .irq_pend(irq_pend)
  );

  // behavioural reference model
  logic [7:0]  m_mode, m_rd;
  logic [15:0] m_rel, m_cnt, m_hold;
  logic        m_gate, m_pend, m_busy, m_out, m_frz, m_pext;

  always @(posedge clk) begin
    bit trig, gate_ok, tc, nbusy, shape, cmdw;
    int ncnt;
    logic [7:0] st;
    logic [15:0] vw;
    if (rst) begin
      m_mode = 0; m_rel = 0; m_cnt = 0; m_hold = 0; m_rd = 0;
      m_gate = 0; m_pend = 0; m_busy = 0; m_out = 0; m_frz = 0; m_pext = 0;
    end else begin
      cmdw    = wr_en && addr == 3'd1;
      trig    = ctr_on && ((cmdw && wdata[1]) || (m_mode[3] && ext_trig && !m_pext));
      gate_ok = m_gate && (!m_mode[4] || ext_gate);
      tc = 0; ncnt = m_cnt; nbusy = m_busy;
      if (!ctr_on) nbusy = 0;
      else if (trig && (!m_busy || m_mode[5])) begin ncnt = m_rel; nbusy = 1; end
      else if (m_busy && gate_ok && cnt_en) begin
        if (m_cnt <= 1) begin
          tc = 1;
          if (m_mode[2]) ncnt = m_rel; else begin ncnt = 0; nbusy = 0; end
        end else ncnt = m_cnt - 1;
      end
      case (m_mode[1:0])
        2'd1:    shape = nbusy && !tc;
        2'd2:    shape = nbusy && (ncnt > (m_rel / 2));
        default: shape = tc;
      endcase
      m_out = m_mode[6] && shape;
      // read path from pre-edge state
      vw = m_frz ? m_hold : m_cnt;
      st = {2'b00, m_pend, 1'b0, m_frz, m_gate, 1'b0, m_busy};
      if (rd_en) begin
        case (addr)
          3'd0: m_rd = m_mode;
          3'd1: m_rd = st;
          3'd2: m_rd = m_rel[7:0];
          3'd3: m_rd = m_rel[15:8];
          3'd4: m_rd = vw[15:8];
          3'd5: m_rd = vw[7:0];
          default: m_rd = 0;
        endcase
      end
      if (!ctr_on) begin m_frz = 0; end
      else if (cmdw && wdata[3]) begin m_hold = m_cnt; m_frz = 1; end
      else if (rd_en && addr == 3'd5) m_frz = 0;
      if (!ctr_on) begin m_gate = 0; m_pend = 0; end
      else begin
        if (cmdw) m_gate = wdata[2];
        if (tc) m_pend = 1; else if (cmdw && wdata[4]) m_pend = 0;
      end
      if (wr_en && addr == 3'd0) m_mode = wdata;
      if (wr_en && addr == 3'd2) m_rel[7:0] = wdata;
      if (wr_en && addr == 3'd3) m_rel[15:8] = wdata;
      m_cnt = ncnt[15:0];
      m_busy = nbusy;
      m_pext = ext_trig;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done && !rst) begin
      chk("R4 busy", 16'(busy), 16'(m_busy));
      chk("R5 irq_pend", 16'(irq_pend), 16'(m_pend));
      chk("R6 ctr_out", 16'(ctr_out), 16'(m_out));
      chk("R9 rdata", 16'(rdata), 16'(m_rd));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(tag, 16'(v), 16'(e));
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk); cnt_en = 1'b0;
    end
  endtask

  task automatic xpulse();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [7:0] h0, l0, h1, l1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset busy", 16'(busy), 16'd0);
    chk("R9 reset out", 16'(ctr_out), 16'd0);
    expect_rd(3'd1, 8'h00, "R9 reset status");
    // R1 reload bytes
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    expect_rd(3'd2, 8'h34, "R1 reload low");
    expect_rd(3'd3, 8'h12, "R1 reload high");
    // R4/R5 single pulse cycle
    wr(3'd2, 8'h05); wr(3'd3, 8'h00);
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h06);
    chk("R3 busy after trigger", 16'(busy), 16'd1);
    strobe(5);
    chk("R4 single cycle ends", 16'(busy), 16'd0);
    expect_rd(3'd1, 8'h24, "R5 pending set");
    wr(3'd1, 8'h14);
    expect_rd(3'd1, 8'h04, "R5 pending cleared");
    // R2 closed gate
    wr(3'd1, 8'h02);
    strobe(3);
    wr(3'd1, 8'h08);
    expect_rd(3'd4, 8'h00, "R2 count high");
    expect_rd(3'd5, 8'h05, "R2 count frozen by gate");
    // R7 latch
    wr(3'd1, 8'h04);
    strobe(2);
    wr(3'd1, 8'h0C);
    strobe(2);
    expect_rd(3'd4, 8'h00, "R7 latched high");
    expect_rd(3'd1, 8'h0D, "R7 freeze status");
    expect_rd(3'd5, 8'h03, "R7 latched low");
    expect_rd(3'd5, 8'h01, "R7 live after release");
    strobe(1);
    wr(3'd1, 8'h14);
    // R3 retrigger
    wr(3'd2, 8'h0A);
    wr(3'd0, 8'h41);
    wr(3'd1, 8'h06);
    chk("R6 oneshot high", 16'(ctr_out), 16'd1);
    strobe(3);
    wr(3'd1, 8'h06);
    wr(3'd1, 8'h0C);
    expect_rd(3'd4, 8'h00, "R3 high");
    expect_rd(3'd5, 8'h07, "R3 trigger ignored");
    wr(3'd0, 8'h61);
    wr(3'd1, 8'h06);
    wr(3'd1, 8'h0C);
    expect_rd(3'd4, 8'h00, "R3 high");
    expect_rd(3'd5, 8'h0A, "R3 retrigger reloads");
    strobe(10);
    chk("R4 cycle done", 16'(busy), 16'd0);
    // R3 external trigger enable
    wr(3'd0, 8'h40);
    xpulse();
    chk("R3 ext trigger disabled", 16'(busy), 16'd0);
    wr(3'd0, 8'h48);
    xpulse();
    chk("R3 ext trigger enabled", 16'(busy), 16'd1);
    strobe(10);
    // R4/R6 continuous square
    wr(3'd2, 8'h04);
    wr(3'd0, 8'h46);
    wr(3'd1, 8'h16);
    strobe(12);
    chk("R4 continuous stays busy", 16'(busy), 16'd1);
    // R2 external gate
    wr(3'd0, 8'h56);
    ext_gate = 1'b0;
    wr(3'd1, 8'h0C); rd(3'd4, h0); rd(3'd5, l0);
    strobe(3);
    wr(3'd1, 8'h0C); rd(3'd4, h1); rd(3'd5, l1);
    chk("R2 ext gate holds count", {h1, l1}, {h0, l0});
    ext_gate = 1'b1;
    strobe(1);
    // R8 counter off
    @(negedge clk); ctr_on = 1'b0;
    wr(3'd1, 8'h0C);
    chk("R8 busy cleared", 16'(busy), 16'd0);
    chk("R8 pending cleared", 16'(irq_pend), 16'd0);
    expect_rd(3'd1, 8'h00, "R8 status zero while off");
    @(negedge clk); ctr_on = 1'b1;
    expect_rd(3'd1, 8'h00, "R8 status zero after on");
    // R6 output disabled
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h06);
    chk("R6 output disabled", 16'(ctr_out), 16'd0);
    chk("R3 busy", 16'(busy), 16'd1);
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule